// File: doc/BRIEF.md
# Address-Range Access Watchpoint Unit

This block observes the accesses that a memory arbiter grants and raises an interrupt when one of them touches a watched window. It holds four independent watchpoints. Each watchpoint is programmed with an inclusive address window, a mask of the access kinds it reacts to (read, write) and a mask of the requesting clients it watches. An observed access hits a watchpoint when its address lies inside the window, its kind is enabled and at least one of its participating clients is watched.

When a watchpoint hits, it stores a diagnostic record: the watched clients that took part, the address, the access kind, the lowest-numbered of those clients and the access size. The record stays frozen until software acknowledges that watchpoint, so it always describes the first offending access. Separately, a global status register latches each hit. A global enable mask selects which status bits drive the single interrupt line, and a global acknowledge register clears status bits. Software reaches everything through a simple register write port with a combinational read data path.

Top module: `wpt_unit`

## Requirements
- R1: After reset every window bound, access-kind mask, client mask, capture field, held flag, status bit and enable bit reads zero, and `irq` is low.
- R2: An access can hit watchpoint n only when low bound <= address <= high bound, with both ends inclusive. A window whose low bound exceeds its high bound never hits.
- R3: `obs_op` value 0 is a read and 1 is a write. An access can hit only when bit `obs_op` of the watchpoint's access-kind mask (slot offset 2) is set.
- R4: The hitting client set is `obs_clients` AND the client mask (slot offset 3). A hit needs `obs_valid` high and a nonzero hitting set.
- R5: A hit on watchpoint n sets global status bit n at the next clock edge. The masked status reads as status AND enable. `irq` is high exactly when the masked status is nonzero.
- R6: On a hit taken by a watchpoint that is not holding a record, the watchpoint captures the hitting client set (offset 5), the address (offset 6), the access kind (offset 7), the lowest index in the hitting set (offset 8) and `obs_size` (offset 9). It also sets its held flag (offset 4 read).
- R7: While its held flag is set, a watchpoint's capture fields ignore further hits. Those hits still set its global status bit.
- R8: Any write to a watchpoint's offset 4 clears its held flag. The next hit then captures a new record.
- R9: Writing the global acknowledge register (global offset 3) clears each status bit whose data bit is 1 and leaves the other bits unchanged. If a hit arrives in the same cycle, the status bit stays set.
- R10: Register address bit 6 selects the global space (offset 0 enable, 1 status, 2 masked status, 3 acknowledge). Otherwise bits 5:4 pick the watchpoint and bits 3:0 the slot offset (0 low bound, 1 high bound, 2 access-kind mask, 3 client mask). Configuration and enable registers read back what was written, and acknowledge locations read zero.
- R11: Watchpoints are evaluated independently. One access can hit several watchpoints in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address (bit 6 global space, 5:4 watchpoint, 3:0 offset) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| obs_valid | input | 1 | An observed access is present this cycle |
| obs_addr | input | 32 | Address of the observed access |
| obs_op | input | 1 | Access kind: 0 read, 1 write |
| obs_clients | input | 8 | One bit per client taking part in the access |
| obs_size | input | 3 | Size code of the access |
| irq | output | 1 | OR of the enabled status bits |

## Verification
The assertions assume that observation fields are only meaningful while `obs_valid` is high. They also assume that a global acknowledge or watchpoint acknowledge in the same cycle as a hit on that watchpoint is resolved in favour of the hit, so every clearing property is qualified by the absence of a hit. The bench keeps to one register write or one observed access per clock, driven on the falling edge. It never lets an acknowledge coincide with a hit, so the ordering of each expected record is unambiguous. Its stimulus sweeps the window boundaries, every access-kind mask against both kinds, and all 256 client patterns against one client mask.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

  // Offsets inside one watchpoint's register slot
  typedef enum logic [3:0] {
    SO_LO  = 4'd0,
    SO_HI  = 4'd1,
    SO_OPM = 4'd2,
    SO_CLM = 4'd3,
    SO_ACK = 4'd4,
    SO_CCL = 4'd5,
    SO_CAD = 4'd6,
    SO_COP = 4'd7,
    SO_CFS = 4'd8,
    SO_CSZ = 4'd9
  } slot_off_e;

  // Offsets inside the global register space
  typedef enum logic [1:0] {
    GO_EN   = 2'd0,
    GO_STAT = 2'd1,
    GO_MSK  = 2'd2,
    GO_ACK  = 2'd3
  } glob_off_e;

  localparam int unsigned DATA_W = 32;

endpackage

// File: rtl/wpt_slot.sv
module wpt_slot
  import wpt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int N_CLIENT = 8,
  parameter int N_OP     = 2,
  parameter int SIZE_W   = 3,
  parameter int OPW      = 1,
  parameter int CIW      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [3:0]          cfg_off,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic                obs_valid,
  input  logic [ADDR_W-1:0]   obs_addr,
  input  logic [OPW-1:0]      obs_op,
  input  logic [N_CLIENT-1:0] obs_clients,
  input  logic [SIZE_W-1:0]   obs_size,
  output logic                hit,
  output logic                held,
  output logic                ack_pulse,
  output logic                win_empty,
  output logic [DATA_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]   cap_addr_o,
  output logic [N_CLIENT-1:0] cap_clients_o,
  output logic [CIW-1:0]      cap_first_o
);

  // Inclusive window test
  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Index of the lowest set bit (zero for an empty vector)
  function automatic logic [CIW-1:0] lowest_set(input logic [N_CLIENT-1:0] v);
    logic [CIW-1:0] idx;
    idx = '0;
    for (int k = N_CLIENT - 1; k >= 0; k--) begin
      if (v[k]) idx = CIW'(k);
    end
    return idx;
  endfunction

  logic [ADDR_W-1:0]   lo_q, hi_q;
  logic [N_OP-1:0]     opm_q;
  logic [N_CLIENT-1:0] clm_q;
  logic                held_q;
  logic [N_CLIENT-1:0] cap_cl_q;
  logic [ADDR_W-1:0]   cap_ad_q;
  logic [OPW-1:0]      cap_op_q;
  logic [CIW-1:0]      cap_fs_q;
  logic [SIZE_W-1:0]   cap_sz_q;

  logic [N_CLIENT-1:0] hit_clients;
  logic                kind_ok;
  logic                take;

  assign hit_clients = obs_clients & clm_q;
  assign kind_ok     = opm_q[obs_op];
  assign hit         = obs_valid && (|hit_clients) && kind_ok
                       && in_window(obs_addr, lo_q, hi_q);
  assign ack_pulse   = cfg_we && (cfg_off == SO_ACK);
  assign take        = hit && (!held_q || ack_pulse);
  assign win_empty   = lo_q > hi_q;

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      opm_q <= '0;
      clm_q <= '0;
    end else if (cfg_we) begin
      case (cfg_off)
        SO_LO:   lo_q  <= cfg_wdata[ADDR_W-1:0];
        SO_HI:   hi_q  <= cfg_wdata[ADDR_W-1:0];
        SO_OPM:  opm_q <= cfg_wdata[N_OP-1:0];
        SO_CLM:  clm_q <= cfg_wdata[N_CLIENT-1:0];
        default: ;
      endcase
    end
  end

  // Capture record, frozen while held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= 1'b0;
      cap_cl_q <= '0;
      cap_ad_q <= '0;
      cap_op_q <= '0;
      cap_fs_q <= '0;
      cap_sz_q <= '0;
    end else if (take) begin
      held_q   <= 1'b1;
      cap_cl_q <= hit_clients;
      cap_ad_q <= obs_addr;
      cap_op_q <= obs_op;
      cap_fs_q <= lowest_set(hit_clients);
      cap_sz_q <= obs_size;
    end else if (ack_pulse) begin
      held_q   <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (cfg_off)
      SO_LO:   rd_data = DATA_W'(lo_q);
      SO_HI:   rd_data = DATA_W'(hi_q);
      SO_OPM:  rd_data = DATA_W'(opm_q);
      SO_CLM:  rd_data = DATA_W'(clm_q);
      SO_ACK:  rd_data = DATA_W'(held_q);
      SO_CCL:  rd_data = DATA_W'(cap_cl_q);
      SO_CAD:  rd_data = DATA_W'(cap_ad_q);
      SO_COP:  rd_data = DATA_W'(cap_op_q);
      SO_CFS:  rd_data = DATA_W'(cap_fs_q);
      SO_CSZ:  rd_data = DATA_W'(cap_sz_q);
      default: rd_data = '0;
    endcase
  end

  assign held          = held_q;
  assign cap_addr_o    = cap_ad_q;
  assign cap_clients_o = cap_cl_q;
  assign cap_first_o   = cap_fs_q;

endmodule

// File: rtl/wpt_irq_ctl.sv
module wpt_irq_ctl #(
  parameter int N_WP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_WP-1:0] hit_vec,
  input  logic            en_we,
  input  logic            ack_we,
  input  logic [N_WP-1:0] wbits,
  output logic [N_WP-1:0] enable,
  output logic [N_WP-1:0] status,
  output logic [N_WP-1:0] masked,
  output logic            irq
);

  logic [N_WP-1:0] clr_bits;

  assign clr_bits = ack_we ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
      status <= '0;
    end else begin
      if (en_we) enable <= wbits;
      // a hit in the same cycle wins over the clear
      status <= (status & ~clr_bits) | hit_vec;
    end
  end

  assign masked = status & enable;
  assign irq    = |masked;

endmodule

// File: rtl/wpt_unit.sv
module wpt_unit
  import wpt_pkg::*;
#(
  parameter int N_WP     = 4,
  parameter int ADDR_W   = 32,
  parameter int N_CLIENT = 8,
  parameter int N_OP     = 2,
  parameter int SIZE_W   = 3,
  localparam int SLOT_BITS = $clog2(N_WP),
  localparam int REG_AW    = SLOT_BITS + 5,
  localparam int OPW       = (N_OP > 1) ? $clog2(N_OP) : 1,
  localparam int CIW       = (N_CLIENT > 1) ? $clog2(N_CLIENT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wen,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                obs_valid,
  input  logic [ADDR_W-1:0]   obs_addr,
  input  logic [OPW-1:0]      obs_op,
  input  logic [N_CLIENT-1:0] obs_clients,
  input  logic [SIZE_W-1:0]   obs_size,
  output logic                irq
);

  // Address decode
  logic                 glob_sel;
  logic                 glob_hit;
  logic [SLOT_BITS-1:0] slot_idx;
  logic [3:0]           slot_off;
  logic [1:0]           glob_off;

  assign glob_sel = reg_addr[REG_AW-1];
  assign glob_hit = glob_sel && (reg_addr[REG_AW-2:2] == '0);
  assign slot_idx = reg_addr[4 +: SLOT_BITS];
  assign slot_off = reg_addr[3:0];
  assign glob_off = reg_addr[1:0];

  // Named events for the checker
  logic [N_WP-1:0]          hit_vec;
  logic [N_WP-1:0]          held_vec;
  logic [N_WP-1:0]          ack_vec;
  logic [N_WP-1:0]          win_empty_vec;
  logic [N_WP-1:0]          gstat;
  logic [N_WP-1:0]          genable;
  logic [N_WP-1:0]          gmasked;
  logic                     gack_we;
  logic                     gen_we;
  logic [N_WP-1:0]          gack_bits;
  logic [N_WP*ADDR_W-1:0]   cap_addr_flat;
  logic [N_WP*N_CLIENT-1:0] cap_cl_flat;
  logic [N_WP*CIW-1:0]      cap_first_flat;
  logic [DATA_W-1:0]        slot_rd [N_WP];

  assign gack_we   = reg_wen && glob_hit && (glob_off == GO_ACK);
  assign gen_we    = reg_wen && glob_hit && (glob_off == GO_EN);
  assign gack_bits = reg_wdata[N_WP-1:0];

  for (genvar i = 0; i < N_WP; i++) begin : g_slot
    logic slot_we;
    assign slot_we = reg_wen && !glob_sel && (slot_idx == SLOT_BITS'(i));

    wpt_slot #(
      .ADDR_W   (ADDR_W),
      .N_CLIENT (N_CLIENT),
      .N_OP     (N_OP),
      .SIZE_W   (SIZE_W),
      .OPW      (OPW),
      .CIW      (CIW)
    ) u_slot (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_we        (slot_we),
      .cfg_off       (slot_off),
      .cfg_wdata     (reg_wdata),
      .obs_valid     (obs_valid),
      .obs_addr      (obs_addr),
      .obs_op        (obs_op),
      .obs_clients   (obs_clients),
      .obs_size      (obs_size),
      .hit           (hit_vec[i]),
      .held          (held_vec[i]),
      .ack_pulse     (ack_vec[i]),
      .win_empty     (win_empty_vec[i]),
      .rd_data       (slot_rd[i]),
      .cap_addr_o    (cap_addr_flat[i*ADDR_W +: ADDR_W]),
      .cap_clients_o (cap_cl_flat[i*N_CLIENT +: N_CLIENT]),
      .cap_first_o   (cap_first_flat[i*CIW +: CIW])
    );
  end

  wpt_irq_ctl #(.N_WP(N_WP)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_vec (hit_vec),
    .en_we   (gen_we),
    .ack_we  (gack_we),
    .wbits   (gack_bits),
    .enable  (genable),
    .status  (gstat),
    .masked  (gmasked),
    .irq     (irq)
  );

  // Read path
  always_comb begin
    reg_rdata = '0;
    if (glob_sel) begin
      if (glob_hit) begin
        case (glob_off)
          GO_EN:   reg_rdata = DATA_W'(genable);
          GO_STAT: reg_rdata = DATA_W'(gstat);
          GO_MSK:  reg_rdata = DATA_W'(gmasked);
          default: reg_rdata = '0;
        endcase
      end
    end else begin
      reg_rdata = slot_rd[slot_idx];
    end
  end

endmodule

// File: rtl/wpt_unit_chk.sv
module wpt_unit_chk #(
  parameter int N_WP     = 4,
  parameter int ADDR_W   = 32,
  parameter int N_CLIENT = 8,
  parameter int CIW      = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     obs_valid,
  input logic                     irq,
  input logic [N_WP-1:0]          hit_vec,
  input logic [N_WP-1:0]          held_vec,
  input logic [N_WP-1:0]          ack_vec,
  input logic [N_WP-1:0]          win_empty_vec,
  input logic [N_WP-1:0]          gstat,
  input logic [N_WP-1:0]          genable,
  input logic                     gack_we,
  input logic [N_WP-1:0]          gack_bits,
  input logic [N_WP*ADDR_W-1:0]   cap_addr_flat,
  input logic [N_WP*N_CLIENT-1:0] cap_cl_flat,
  input logic [N_WP*CIW-1:0]      cap_first_flat
);

  p_no_valid_no_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !obs_valid |-> (hit_vec == '0));

  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((genable != '0) && (gstat != '0)));

  for (genvar i = 0; i < N_WP; i++) begin : g_chk
    p_hit_sets_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[i] |=> gstat[i]);

    p_empty_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      win_empty_vec[i] |-> !hit_vec[i]);

    p_capture_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (held_vec[i] && !ack_vec[i]) |=>
        ($stable(cap_addr_flat[i*ADDR_W +: ADDR_W]) &&
         $stable(cap_first_flat[i*CIW +: CIW]) &&
         $stable(cap_cl_flat[i*N_CLIENT +: N_CLIENT])));

    p_first_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      held_vec[i] |->
        (cap_cl_flat[i*N_CLIENT + int'(cap_first_flat[i*CIW +: CIW])] &&
         ((cap_cl_flat[i*N_CLIENT +: N_CLIENT] &
           ((N_CLIENT'(1) << cap_first_flat[i*CIW +: CIW]) - N_CLIENT'(1))) == '0)));

    p_ack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vec[i] && !hit_vec[i]) |=> !held_vec[i]);

    p_status_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (gack_we && gack_bits[i] && !hit_vec[i]) |=> !gstat[i]);
  end

endmodule

bind wpt_unit wpt_unit_chk #(
  .N_WP     (N_WP),
  .ADDR_W   (ADDR_W),
  .N_CLIENT (N_CLIENT),
  .CIW      (CIW)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .obs_valid      (obs_valid),
  .irq            (irq),
  .hit_vec        (hit_vec),
  .held_vec       (held_vec),
  .ack_vec        (ack_vec),
  .win_empty_vec  (win_empty_vec),
  .gstat          (gstat),
  .genable        (genable),
  .gack_we        (gack_we),
  .gack_bits      (gack_bits),
  .cap_addr_flat  (cap_addr_flat),
  .cap_cl_flat    (cap_cl_flat),
  .cap_first_flat (cap_first_flat)
);

// File: tb/wpt_unit_bench.sv
module wpt_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        obs_valid = 1'b0;
  logic [31:0] obs_addr = '0;
  logic [0:0]  obs_op = '0;
  logic [7:0]  obs_clients = '0;
  logic [2:0]  obs_size = '0;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wpt_unit u_wpt_unit (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .obs_valid(obs_valid),
    .obs_addr(obs_addr), .obs_op(obs_op), .obs_clients(obs_clients),
    .obs_size(obs_size), .irq(irq)
  );

  // Reference model state
  logic [31:0] m_lo [4];
  logic [31:0] m_hi [4];
  logic [1:0]  m_opm [4];
  logic [7:0]  m_clm [4];
  logic        m_held [4];
  logic [7:0]  m_ccl [4];
  logic [31:0] m_cad [4];
  logic        m_cop [4];
  logic [2:0]  m_cfs [4];
  logic [2:0]  m_csz [4];
  logic [3:0]  m_stat = '0;
  logic [3:0]  m_en = '0;

  function automatic logic [6:0] sa(input int i, input int o);
    return {1'b0, 2'(i), 4'(o)};
  endfunction

  function automatic logic [6:0] ga(input int g);
    return 7'h40 + 7'(g);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
    if (a[6]) begin
      if (a[1:0] == 2'd0) m_en = d[3:0];
      if (a[1:0] == 2'd3) m_stat = m_stat & ~d[3:0];
    end else begin
      case (a[3:0])
        4'd0: m_lo[a[5:4]] = d;
        4'd1: m_hi[a[5:4]] = d;
        4'd2: m_opm[a[5:4]] = d[1:0];
        4'd3: m_clm[a[5:4]] = d[7:0];
        4'd4: m_held[a[5:4]] = 1'b0;
        default: ;
      endcase
    end
  endtask

  task automatic access(input logic v, input logic [31:0] a, input logic op,
                        input logic [7:0] cl, input logic [2:0] sz);
    @(negedge clk);
    obs_valid = v; obs_addr = a; obs_op = op; obs_clients = cl; obs_size = sz;
    @(negedge clk);
    obs_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] hc;
      logic inside_w;
      logic found;
      hc = cl & m_clm[i];
      inside_w = !(a < m_lo[i]) && !(m_hi[i] < a);
      if (v && hc != 0 && m_opm[i][op] && inside_w) begin
        m_stat[i] = 1'b1;
        if (!m_held[i]) begin
          m_held[i] = 1'b1;
          m_ccl[i] = hc;
          m_cad[i] = a;
          m_cop[i] = op;
          m_csz[i] = sz;
          found = 1'b0;
          for (int k = 0; k < 8; k++) begin
            if (hc[k] && !found) begin
              m_cfs[i] = 3'(k);
              found = 1'b1;
            end
          end
        end
      end
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(sa(i, 4), d); check("R7", $sformatf("held[%0d] %s", i, tag), d, 32'(m_held[i]));
      rd(sa(i, 5), d); check("R6", $sformatf("clients[%0d] %s", i, tag), d, 32'(m_ccl[i]));
      rd(sa(i, 6), d); check("R6", $sformatf("addr[%0d] %s", i, tag), d, m_cad[i]);
      rd(sa(i, 7), d); check("R6", $sformatf("op[%0d] %s", i, tag), d, 32'(m_cop[i]));
      rd(sa(i, 8), d); check("R6", $sformatf("first[%0d] %s", i, tag), d, 32'(m_cfs[i]));
      rd(sa(i, 9), d); check("R6", $sformatf("size[%0d] %s", i, tag), d, 32'(m_csz[i]));
    end
    rd(ga(1), d); check(tag, "status", d, 32'(m_stat));
    rd(ga(2), d); check("R5", $sformatf("masked %s", tag), d, 32'(m_stat & m_en));
    check(tag, "irq", 32'(irq), 32'(|(m_stat & m_en)));
  endtask

  task automatic clear_all();
    for (int i = 0; i < 4; i++) begin
      if (m_held[i]) wr(sa(i, 4), 32'h1);
    end
    wr(ga(3), 32'hF);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] edges [8];
    for (int i = 0; i < 4; i++) begin
      m_lo[i] = '0; m_hi[i] = '0; m_opm[i] = '0; m_clm[i] = '0;
      m_held[i] = 1'b0; m_ccl[i] = '0; m_cad[i] = '0; m_cop[i] = 1'b0;
      m_cfs[i] = '0; m_csz[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      for (int o = 0; o < 4; o++) begin
        rd(sa(i, o), d); check("R1", $sformatf("cfg[%0d][%0d]", i, o), d, 32'h0);
      end
    end
    rd(ga(0), d); check("R1", "enable", d, 32'h0);
    check_all("R1");

    // R10: configuration and readback
    wr(sa(0, 0), 32'h100);  wr(sa(0, 1), 32'h1FF);  wr(sa(0, 2), 32'h3); wr(sa(0, 3), 32'hFF);
    wr(sa(1, 0), 32'h800);  wr(sa(1, 1), 32'h8FF);  wr(sa(1, 2), 32'h0); wr(sa(1, 3), 32'h02);
    wr(sa(2, 0), 32'h3000); wr(sa(2, 1), 32'h3000); wr(sa(2, 2), 32'h1); wr(sa(2, 3), 32'hA5);
    wr(sa(3, 0), 32'h5000); wr(sa(3, 1), 32'h50FF); wr(sa(3, 2), 32'h2); wr(sa(3, 3), 32'h0F);
    wr(ga(0), 32'hF);
    for (int i = 0; i < 4; i++) begin
      rd(sa(i, 0), d); check("R10", "low bound", d, m_lo[i]);
      rd(sa(i, 1), d); check("R10", "high bound", d, m_hi[i]);
      rd(sa(i, 2), d); check("R10", "kind mask", d, 32'(m_opm[i]));
      rd(sa(i, 3), d); check("R10", "client mask", d, 32'(m_clm[i]));
    end
    rd(ga(0), d); check("R10", "enable", d, 32'hF);
    rd(ga(3), d); check("R10", "ack reads zero", d, 32'h0);

    // R2: window boundaries
    edges[0] = 32'hFE;  edges[1] = 32'hFF;  edges[2] = 32'h100; edges[3] = 32'h101;
    edges[4] = 32'h1FE; edges[5] = 32'h1FF; edges[6] = 32'h200; edges[7] = 32'h201;
    for (int e = 0; e < 8; e++) begin
      access(1'b1, edges[e], 1'b1, 8'h01, 3'(e));
      check_all("R2");
      clear_all();
    end

    // R3: every kind mask against both kinds
    for (int m = 0; m < 4; m++) begin
      wr(sa(1, 2), 32'(m));
      for (int op = 0; op < 2; op++) begin
        access(1'b1, 32'h840, 1'(op), 8'h02, 3'd1);
        check_all("R3");
        clear_all();
      end
    end

    // R4: no valid, then all client patterns
    access(1'b0, 32'h3000, 1'b0, 8'hFF, 3'd0);
    check_all("R4");
    for (int c = 0; c < 256; c++) begin
      access(1'b1, 32'h3000, 1'b0, 8'(c), 3'(c));
      check_all("R4");
      clear_all();
    end

    // R7: record frozen while held, status still set
    access(1'b1, 32'h5010, 1'b1, 8'h06, 3'd5);
    wr(ga(3), 32'h8);
    check_all("R9");
    access(1'b1, 32'h5020, 1'b1, 8'h01, 3'd2);
    check_all("R7");

    // R8: release then new capture
    wr(sa(3, 4), 32'h0);
    check_all("R8");
    access(1'b1, 32'h50FF, 1'b1, 8'h08, 3'd7);
    check_all("R8");
    clear_all();

    // R9: selective global acknowledge
    access(1'b1, 32'h150, 1'b0, 8'h80, 3'd3);
    access(1'b1, 32'h5001, 1'b1, 8'h0C, 3'd4);
    wr(ga(3), 32'h1);
    check_all("R9");
    clear_all();

    // R5: enable gating
    wr(ga(0), 32'h6);
    access(1'b1, 32'h5001, 1'b1, 8'h01, 3'd1);
    check_all("R5");
    wr(ga(0), 32'hF);
    check_all("R5");
    clear_all();

    // R11: overlapping windows hit together
    wr(sa(1, 0), 32'h100); wr(sa(1, 1), 32'h1FF); wr(sa(1, 2), 32'h3); wr(sa(1, 3), 32'hFF);
    access(1'b1, 32'h150, 1'b1, 8'h30, 3'd2);
    check_all("R11");
    clear_all();

    // R2: inverted window never hits
    wr(sa(0, 0), 32'h200); wr(sa(0, 1), 32'h100);
    access(1'b1, 32'h180, 1'b0, 8'h01, 3'd6);
    check_all("R2");
    clear_all();

    done = 1;
    summary();
    $finish;
  end

endmodule